// File: doc/BRIEF.md
# Addressed Serial Display-Data Receiver

This block takes display and dimmer settings from a host controller over a three-wire synchronous serial link: a bit clock, a data line and a chip-select line. All three lines are brought into the system clock domain and oversampled. The host first sends an 8-bit device address while chip select is low. It then raises chip select and shifts in a 40-bit payload: 24 segment bits, 14 control bits and a 2-bit direction field. When chip select falls, a frame of exactly the right length with the right address is written into one of three 24-bit digit groups and into the 10-bit dimmer register.

A full picture takes three frames, 144 serial bits in all, one frame per digit group. The outputs drive a display scanner in parallel. Frames are accepted whatever the display is showing, so the host can load a whole picture while the panel is dark. The host may leave the bit clock idling either low or high; only rising edges move data.

Top module: `vfd_link_rx`

## Requirements
- R1: After reset `disp_o` and `dimmer_o` are all zero.
- R2: The address is taken from the last 8 bit-clock rising edges before chip select rises, LSB first. Only the value 8'h83 is accepted. A frame with any other address leaves both outputs unchanged.
- R3: Payload bits are sampled on bit-clock rising edges while chip select is high, LSB first.
  - Payload bits 0..23 are display data; bit k drives bit k of the selected group, and 1 means the segment is on.
  - Bits 24..37 are control; bits 24..33 form the dimmer, with bit 24 as its LSB.
  - Bits 38..39 are the direction field, with bit 38 as its LSB.
- R4: Direction 00 writes `disp_o[23:0]`, 01 writes `disp_o[47:24]` and 10 writes `disp_o[71:48]`. The other two groups keep their values.
- R5: Direction 11 changes no display bit, but the dimmer is still written from the frame.
- R6: A frame whose payload is not exactly 40 bits, whether shorter or longer, changes neither output.
- R7: Outputs change only after chip select falls, and the new values are visible within 4 system clocks of that fall. While a frame is being shifted in, the outputs hold their previous values.
- R8: Frames are received correctly whether the bit clock idles low or high between transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial bit clock; data is sampled on its rising edges |
| sdata_i | input | 1 | Serial data, LSB first |
| cs_i | input | 1 | Chip select: low during the address, high during the payload |
| disp_o | output | 72 | Segment bits; [23:0] group 1, [47:24] group 2, [71:48] group 3 |
| dimmer_o | output | 10 | Dimmer value from the most recent accepted frame |

## Verification
Each serial line passes two synchronizer flops and one edge-detect flop before it reaches the registers. A chip-select fall therefore shows up at the outputs on the third or fourth system clock after the pin changes. The bench waits eight clocks after dropping chip select before it compares the outputs with its model, and it keeps every serial edge at least four clocks from any other edge so that sampling never races. The hold behaviour is checked just before chip select falls, while the new payload is already fully shifted in but not yet committed.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
  localparam int ADDR_W   = 8;
  localparam int DISP_W   = 24;
  localparam int CTRL_W   = 14;
  localparam int DIR_W    = 2;
  localparam int DIM_W    = 10;
  localparam int GROUPS   = 3;
  localparam int FRAME_W  = DISP_W + CTRL_W + DIR_W;
  localparam logic [ADDR_W-1:0] DEV_ADDR = 8'h83;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/vlr_sync.sv
module vlr_sync #(
  parameter int N      = 3,
  parameter int STAGES = vlr_pkg::SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] lvl_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-2:0], in_i[i]};
    end
    assign lvl_o[i] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/vlr_frame.sv
module vlr_frame
  import vlr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int FW = FRAME_W,
  parameter int DW = DISP_W,
  parameter int MW = DIM_W,
  parameter int RW = DIR_W,
  parameter logic [AW-1:0] MY_ADDR = DEV_ADDR
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          sdata_i,
  input  logic          cs_i,
  output logic          commit_o,
  output logic [DW-1:0] disp_o,
  output logic [MW-1:0] dim_o,
  output logic [RW-1:0] dir_o
);
  localparam int CNT_MAX = FW + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic          sclk_q, cs_q;
  logic          sclk_rise, cs_rise, cs_fall;
  logic [AW-1:0] addr_q;
  logic          match_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FW-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_i;
    end
  end

  assign sclk_rise = sclk_i & ~sclk_q;
  assign cs_rise   = cs_i & ~cs_q;
  assign cs_fall   = ~cs_i & cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      match_q <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
    end else begin
      if (!cs_i && sclk_rise) addr_q <= {sdata_i, addr_q[AW-1:1]};
      if (cs_rise) begin
        match_q <= (addr_q == MY_ADDR);
        cnt_q   <= '0;
      end else if (cs_i && sclk_rise) begin
        shift_q <= {sdata_i, shift_q[FW-1:1]};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;  // saturate: long frame
      end
    end
  end

  assign commit_o = cs_fall && match_q && (cnt_q == CNT_W'(FW));
  assign disp_o   = shift_q[DW-1:0];
  assign dim_o    = shift_q[DW +: MW];
  assign dir_o    = shift_q[FW-1 -: RW];

  AST_CNT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CNT_MAX)); // R6
endmodule

// File: rtl/vlr_regs.sv
module vlr_regs
  import vlr_pkg::*;
#(
  parameter int DW = DISP_W,
  parameter int MW = DIM_W,
  parameter int RW = DIR_W,
  parameter int NG = GROUPS
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           commit_i,
  input  logic [DW-1:0]  disp_i,
  input  logic [MW-1:0]  dim_i,
  input  logic [RW-1:0]  dir_i,
  output logic [NG*DW-1:0] disp_o,
  output logic [MW-1:0]  dim_o
);
  logic [NG-1:0] grp_we;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [DW-1:0] grp_q;
    assign grp_we[g] = commit_i && (dir_i == RW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        grp_q <= '0;
      else if (grp_we[g]) grp_q <= disp_i;
    end
    assign disp_o[g*DW +: DW] = grp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dim_o <= '0;
    else if (commit_i) dim_o <= dim_i;   // written for every direction code
  end

  AST_ONE_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grp_we)); // R4
  AST_DISP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(disp_o) |-> $past(commit_i)); // R7
  AST_DIM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dim_o) |-> $past(commit_i)); // R7
endmodule

// File: rtl/vfd_link_rx.sv
module vfd_link_rx
  import vlr_pkg::*;
#(
  parameter int DW = DISP_W,
  parameter int MW = DIM_W,
  parameter int NG = GROUPS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             cs_i,
  output logic [NG*DW-1:0] disp_o,
  output logic [MW-1:0]    dimmer_o
);
  logic [2:0]       lvl;
  logic             commit;
  logic [DW-1:0]    f_disp;
  logic [MW-1:0]    f_dim;
  logic [DIR_W-1:0] f_dir;

  vlr_sync #(.N(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({cs_i, sdata_i, sclk_i}),
    .lvl_o (lvl)
  );

  vlr_frame #(.DW(DW), .MW(MW)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (lvl[0]),
    .sdata_i (lvl[1]),
    .cs_i    (lvl[2]),
    .commit_o(commit),
    .disp_o  (f_disp),
    .dim_o   (f_dim),
    .dir_o   (f_dir)
  );

  vlr_regs #(.DW(DW), .MW(MW), .NG(NG)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit),
    .disp_i  (f_disp),
    .dim_i   (f_dim),
    .dir_i   (f_dir),
    .disp_o  (disp_o),
    .dim_o   (dimmer_o)
  );

  AST_NO_EARLY_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl[2] |=> $stable(dimmer_o)); // R7
endmodule

// File: tb/vfd_link_rx_test.sv
module vfd_link_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, cs = 1'b0;
  logic [71:0] disp;
  logic [9:0]  dim;
  int checks = 0, errors = 0;
  logic [71:0] exp_disp = '0;
  logic [9:0]  exp_dim = '0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vfd_link_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata),
    .cs_i(cs), .disp_o(disp), .dimmer_o(dim)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [71:0] d_exp, input logic [9:0] m_exp);
    checks++;
    if (disp !== d_exp || dim !== m_exp) begin
      errors++;
      $display("FAIL %s disp=%h dim=%h expected disp=%h dim=%h", req, disp, dim, d_exp, m_exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic idle_hi);
    sclk = 1'b0; sdata = b; wait_clk(HALF);
    sclk = 1'b1; wait_clk(HALF);
    if (!idle_hi) sclk = 1'b0;
  endtask

  // bench model of commit rules
  task automatic model(input logic [7:0] a, input logic [39:0] p, input int nb);
    if (a == 8'h83 && nb == 40) begin
      exp_dim = p[33:24];
      case (p[39:38])
        2'b00: exp_disp[23:0]  = p[23:0];
        2'b01: exp_disp[47:24] = p[23:0];
        2'b10: exp_disp[71:48] = p[23:0];
        default: ;
      endcase
    end
  endtask

  task automatic frame(input string req, input logic [7:0] a, input logic [39:0] p,
                       input int nb, input logic idle_hi);
    logic [71:0] od; logic [9:0] om;
    sclk = idle_hi; cs = 1'b0; wait_clk(HALF);
    for (int i = 0; i < 8; i++) send_bit(a[i], idle_hi);
    wait_clk(HALF); cs = 1'b1; wait_clk(HALF);
    for (int i = 0; i < nb; i++) send_bit(i < 40 ? p[i] : 1'b1, idle_hi);
    wait_clk(HALF);
    od = exp_disp; om = exp_dim;
    check({req, "/R7 hold"}, od, om);
    cs = 1'b0; wait_clk(8);
    model(a, p, nb);
    check(req, exp_disp, exp_dim);
  endtask

  initial begin
    void'($urandom(32'd1406));
    wait_clk(3);
    check("R1", 72'h0, 10'h0);
    rst_n = 1'b1; wait_clk(3);
    check("R1", 72'h0, 10'h0);
    frame("R4 g1", 8'h83, {2'b00, 14'h0155, 24'hA5C3F0}, 40, 1'b0);
    frame("R4 g2", 8'h83, {2'b01, 14'h02AA, 24'h123456}, 40, 1'b0);
    frame("R8 g3 idle high", 8'h83, {2'b10, 14'h3C01, 24'hFFFFFF}, 40, 1'b1);
    frame("R3 dim lsb", 8'h83, {2'b00, 14'h0001, 24'h000001}, 40, 1'b1);
    frame("R5 dir11", 8'h83, {2'b11, 14'h03FF, 24'h0F0F0F}, 40, 1'b0);
    frame("R2 bad addr", 8'hC1, {2'b00, 14'h0000, 24'hDEADBE}, 40, 1'b0);
    frame("R2 bad addr", 8'h82, {2'b01, 14'h0123, 24'h777777}, 40, 1'b1);
    frame("R6 short", 8'h83, {2'b00, 14'h0222, 24'hBBBBBB}, 39, 1'b0);
    frame("R6 long", 8'h83, {2'b00, 14'h0222, 24'hCCCCCC}, 41, 1'b1);
    for (int k = 0; k < 30; k++) begin
      logic [7:0] a; logic [39:0] p; int nb; int r;
      r = $urandom_range(9, 0);
      a = (r < 8) ? 8'h83 : 8'($urandom);
      p = {$urandom, $urandom};
      r = $urandom_range(9, 0);
      nb = (r == 0) ? 39 : (r == 1) ? 41 : 40;
      frame("R3/R4 random", a, p, nb, 1'($urandom));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule